// File: doc/BRIEF.md
# Single-Cycle RISC Core

This block is a 32-bit processor core that finishes every instruction in one clock cycle. It runs a small load/store instruction subset: register add and subtract, OR with an immediate, word load, word store and branch-if-equal. It holds a program counter, a 32-entry register file, an arithmetic unit, an immediate extender, a 256-word instruction store and a 256-word data store. Both stores are byte-addressed but hold whole words, so address bits [9:2] pick the word. The program counter, the register file and the data store all change on the same rising clock edge. Register file and data store reads are combinational.

Software loads the instruction store through a preload write port while reset is held. After reset is released, the core fetches from address 0. A debug port reads any data word combinationally, and the current program counter is always visible on an output. The decoder sorts each fetched word into one of seven instruction kinds: K_ADDU, K_SUBU, K_ORI, K_LW, K_SW, K_BEQ and K_NOP. Each kind maps to one fixed set of datapath controls. Because the core has no multi-cycle sequencing, the only transition is from the current program counter to the next one on every clock. That next value is PC+4, or the branch target when K_BEQ finds its two operands equal.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high reset sets the PC to 0 and clears all 32 registers. After reset, an untouched register reads 0.
- R2: addu is encoded as op[31:26]=0x00 and funct[5:0]=0x21. It writes R[rd] = R[rs] + R[rt] modulo 2^32, with rs=[25:21], rt=[20:16] and rd=[15:11].
- R3: subu is encoded as op 0x00 and funct 0x23. It writes R[rd] = R[rs] - R[rt] modulo 2^32.
- R4: ori is encoded as op 0x0D. It writes R[rt] = R[rs] OR the zero-extended 16-bit immediate in bits [15:0].
- R5: lw is encoded as op 0x23. It writes R[rt] = Mem[R[rs] + sign-extended imm16]. The word index is address bits [9:2].
- R6: sw is encoded as op 0x2B. It stores R[rt] to Mem[R[rs] + sign-extended imm16] and writes no register.
- R7: beq is encoded as op 0x04. When R[rs] == R[rt], the PC becomes PC + 4 + (sign-extended imm16 << 2). In every other case, the PC becomes PC + 4.
- R8: Register 0 always reads 0, and writes that target it are dropped.
- R9: Any other opcode, and any op-0x00 word with a funct other than 0x21 or 0x23, changes no register and no memory word. It only advances the PC by 4.
- R10: A store is visible on the debug port from the cycle after its clock edge. The debug port reads the word at index dbg_addr combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pre_we | input | 1 | Instruction store preload write enable |
| pre_addr | input | 8 | Instruction store word index for preload |
| pre_data | input | 32 | Instruction word to preload |
| dbg_addr | input | 8 | Data store word index for debug read |
| dbg_data | output | 32 | Data word at dbg_addr |
| pc_o | output | 32 | Current program counter |

## Verification
The assertions assume that every instruction word the core fetches after reset is a defined value. They also assume reset is not raised again once released, because the PC-step properties look one cycle back. The bench meets both conditions. It preloads all 256 instruction words (unused ones as zero, which decodes as K_NOP) while reset is held, then releases reset once at a falling edge. The program ends in a self-branch so that the PC stays inside the loaded region.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_ORI   = 6'h0D;
    localparam logic [5:0] OP_LW    = 6'h23;
    localparam logic [5:0] OP_SW    = 6'h2B;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] FN_ADDU  = 6'h21;
    localparam logic [5:0] FN_SUBU  = 6'h23;

    typedef enum logic [2:0] {
        K_NOP, K_ADDU, K_SUBU, K_ORI, K_LW, K_SW, K_BEQ
    } kind_e;

    typedef enum logic [1:0] {
        ALU_ADD, ALU_SUB, ALU_OR
    } alu_op_e;

    typedef struct packed {
        logic    reg_wr;
        logic    dst_rd;
        logic    alu_imm;
        logic    ext_sign;
        logic    mem_wr;
        logic    mem_to_reg;
        logic    branch;
        alu_op_e alu_op;
    } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_pkg::*;
(
    input  logic [5:0] op,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);

    kind_e kind;

    // classify the fetched word
    always_comb begin
        kind = K_NOP;
        unique case (op)
            OP_RTYPE: begin
                if (funct == FN_ADDU)      kind = K_ADDU;
                else if (funct == FN_SUBU) kind = K_SUBU;
                else                       kind = K_NOP;
            end
            OP_ORI:  kind = K_ORI;
            OP_LW:   kind = K_LW;
            OP_SW:   kind = K_SW;
            OP_BEQ:  kind = K_BEQ;
            default: kind = K_NOP;
        endcase
    end

    // control set per kind
    always_comb begin
        ctrl        = '0;
        ctrl.alu_op = ALU_ADD;
        unique case (kind)
            K_ADDU: begin
                ctrl.reg_wr = 1'b1;
                ctrl.dst_rd = 1'b1;
            end
            K_SUBU: begin
                ctrl.reg_wr = 1'b1;
                ctrl.dst_rd = 1'b1;
                ctrl.alu_op = ALU_SUB;
            end
            K_ORI: begin
                ctrl.reg_wr  = 1'b1;
                ctrl.alu_imm = 1'b1;
                ctrl.alu_op  = ALU_OR;
            end
            K_LW: begin
                ctrl.reg_wr     = 1'b1;
                ctrl.alu_imm    = 1'b1;
                ctrl.ext_sign   = 1'b1;
                ctrl.mem_to_reg = 1'b1;
            end
            K_SW: begin
                ctrl.alu_imm  = 1'b1;
                ctrl.ext_sign = 1'b1;
                ctrl.mem_wr   = 1'b1;
            end
            K_BEQ: begin
                ctrl.ext_sign = 1'b1;
                ctrl.branch   = 1'b1;
            end
            default: ctrl = '0;
        endcase
    end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int NREG = 32,
    parameter int W    = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] ra,
    input  logic [AW-1:0] rb,
    output logic [W-1:0]  qa,
    output logic [W-1:0]  qb
);

    logic [W-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && (waddr != '0)) begin
            regs[waddr] <= wdata;
        end
    end

    assign qa = regs[ra];
    assign qb = regs[rb];

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y
);

    always_comb begin
        unique case (op)
            ALU_SUB: y = a - b;
            ALU_OR:  y = a | b;
            default: y = a + b;
        endcase
    end

endmodule

// File: rtl/sc_dmem.sv
module sc_dmem #(
    parameter int W  = 32,
    parameter int AW = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [W-1:0]  rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_b
);

    logic [W-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (we) words[waddr] <= wdata;
    end

    assign rdata_a = words[raddr_a];
    assign rdata_b = words[raddr_b];

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int W       = 32,
    parameter int NREG    = 32,
    parameter int IMEM_AW = 8,
    parameter int DMEM_AW = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pre_we,
    input  logic [IMEM_AW-1:0] pre_addr,
    input  logic [W-1:0]       pre_data,
    input  logic [DMEM_AW-1:0] dbg_addr,
    output logic [W-1:0]       dbg_data,
    output logic [W-1:0]       pc_o
);

    localparam int IDEPTH = 1 << IMEM_AW;
    localparam int RAW    = $clog2(NREG);

    logic [W-1:0] imem [IDEPTH];
    logic [W-1:0] pc_q, pc_d, pc_plus4, br_off;
    logic [W-1:0] instr, imm_ext, rs_val, rt_val, alu_b, alu_y, dm_rdata, wb_data;
    logic [RAW-1:0] rf_waddr;
    logic rf_we, dm_we, taken;
    ctrl_t ctrl;

    always_ff @(posedge clk) begin
        if (pre_we) imem[pre_addr] <= pre_data;
    end

    assign instr = imem[pc_q[IMEM_AW+1:2]];

    sc_decode dec_i (
        .op   (instr[31:26]),
        .funct(instr[5:0]),
        .ctrl (ctrl)
    );

    assign imm_ext = ctrl.ext_sign ? {{(W-16){instr[15]}}, instr[15:0]}
                                   : {{(W-16){1'b0}}, instr[15:0]};

    assign rf_waddr = ctrl.dst_rd ? instr[15:11] : instr[20:16];
    assign rf_we    = ctrl.reg_wr;

    sc_regfile #(.NREG(NREG), .W(W)) rf_i (
        .clk  (clk),
        .rst  (rst),
        .we   (rf_we),
        .waddr(rf_waddr),
        .wdata(wb_data),
        .ra   (instr[25:21]),
        .rb   (instr[20:16]),
        .qa   (rs_val),
        .qb   (rt_val)
    );

    assign alu_b = ctrl.alu_imm ? imm_ext : rt_val;

    sc_alu #(.W(W)) alu_i (
        .a (rs_val),
        .b (alu_b),
        .op(ctrl.alu_op),
        .y (alu_y)
    );

    assign dm_we = ctrl.mem_wr & ~rst;

    sc_dmem #(.W(W), .AW(DMEM_AW)) dm_i (
        .clk    (clk),
        .we     (dm_we),
        .waddr  (alu_y[DMEM_AW+1:2]),
        .wdata  (rt_val),
        .raddr_a(alu_y[DMEM_AW+1:2]),
        .rdata_a(dm_rdata),
        .raddr_b(dbg_addr),
        .rdata_b(dbg_data)
    );

    assign wb_data = ctrl.mem_to_reg ? dm_rdata : alu_y;

    assign pc_plus4 = pc_q + W'(4);
    assign br_off   = {imm_ext[W-3:0], 2'b00};
    assign taken    = ctrl.branch && (rs_val == rt_val);
    assign pc_d     = taken ? (pc_plus4 + br_off) : pc_plus4;

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_d;
    end

    assign pc_o = pc_q;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
    import sc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [31:0] pc,
    input logic [31:0] instr,
    input logic [31:0] rs_val,
    input logic [31:0] rt_val,
    input logic        rf_we,
    input logic        dm_we
);

    p_rs_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (instr[25:21] == 5'd0) |-> (rs_val == 32'd0));

    p_rt_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (instr[20:16] == 5'd0) |-> (rt_val == 32'd0));

    p_store_no_regwr_r6: assert property (@(posedge clk) disable iff (rst)
        (instr[31:26] == OP_SW) |-> !rf_we);

    p_memwr_only_store_r6: assert property (@(posedge clk) disable iff (rst)
        dm_we |-> (instr[31:26] == OP_SW));

    p_branch_taken_r7: assert property (@(posedge clk) disable iff (rst)
        ((instr[31:26] == OP_BEQ) && (rs_val == rt_val)) |=>
        (pc == $past(pc) + 32'd4 + {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00}));

    p_pc_step_r7: assert property (@(posedge clk) disable iff (rst)
        !((instr[31:26] == OP_BEQ) && (rs_val == rt_val)) |=> (pc == $past(pc) + 32'd4));

endmodule

bind sc_core sc_core_chk chk_i (
    .clk   (clk),
    .rst   (rst),
    .pc    (pc_q),
    .instr (instr),
    .rs_val(rs_val),
    .rt_val(rt_val),
    .rf_we (rf_we),
    .dm_we (dm_we)
);

// File: tb/sc_core_tb_top.sv
module sc_core_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        pre_we;
    logic [7:0]  pre_addr;
    logic [31:0] pre_data;
    logic [7:0]  dbg_addr;
    logic [31:0] dbg_data;
    logic [31:0] pc_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [31:0] prog [256];
    logic [31:0] m_pc;
    logic [31:0] m_reg [32];
    logic [31:0] m_mem [int];

    always #5 clk = ~clk;

    sc_core dut_i (
        .clk     (clk),
        .rst     (rst),
        .pre_we  (pre_we),
        .pre_addr(pre_addr),
        .pre_data(pre_data),
        .dbg_addr(dbg_addr),
        .dbg_data(dbg_data),
        .pc_o    (pc_o)
    );

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, int fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
    endfunction

    function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
        return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic m_write(int r, logic [31:0] v);
        if (r != 0) m_reg[r] = v;
    endtask

    task automatic model_step();
        logic [31:0] ins, a, b, sx, zx, nxt, addr;
        int rs, rt, rd;
        ins = prog[m_pc[9:2]];
        rs  = int'(ins[25:21]);
        rt  = int'(ins[20:16]);
        rd  = int'(ins[15:11]);
        a   = m_reg[rs];
        b   = m_reg[rt];
        sx  = {{16{ins[15]}}, ins[15:0]};
        zx  = {16'd0, ins[15:0]};
        nxt = m_pc + 32'd4;
        addr = a + sx;
        case (ins[31:26])
            6'h00: begin
                if (ins[5:0] == 6'h21)      m_write(rd, a + b);
                else if (ins[5:0] == 6'h23) m_write(rd, a - b);
            end
            6'h0D: m_write(rt, a | zx);
            6'h23: m_write(rt, m_mem.exists(int'(addr[9:2])) ? m_mem[int'(addr[9:2])] : 32'hx);
            6'h2B: m_mem[int'(addr[9:2])] = b;
            6'h04: if (a == b) nxt = m_pc + 32'd4 + (sx << 2);
            default: ;
        endcase
        m_pc = nxt;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) prog[i] = 32'd0;
        prog[0]  = enc_i(8'h0D, 0, 1, 16'h1234);
        prog[1]  = enc_i(8'h0D, 0, 2, 16'hFFF0);
        prog[2]  = enc_r(1, 2, 3, 8'h21);
        prog[3]  = enc_r(1, 2, 4, 8'h23);
        prog[4]  = enc_i(8'h2B, 0, 3, 8);
        prog[5]  = enc_i(8'h2B, 0, 4, 12);
        prog[6]  = enc_i(8'h0D, 0, 5, 16'h0010);
        prog[7]  = enc_i(8'h23, 5, 6, 16'hFFFC);
        prog[8]  = enc_i(8'h2B, 0, 6, 16);
        prog[9]  = enc_i(8'h0D, 0, 0, 16'h5555);
        prog[10] = enc_r(1, 1, 0, 8'h21);
        prog[11] = enc_i(8'h2B, 0, 0, 20);
        prog[12] = enc_i(8'h2B, 0, 7, 24);
        prog[13] = enc_i(8'h04, 1, 2, 5);
        prog[14] = enc_i(8'h04, 1, 1, 2);
        prog[15] = enc_i(8'h0D, 0, 8, 16'h0BAD);
        prog[16] = enc_i(8'h0D, 0, 8, 16'h0BAD);
        prog[17] = 32'hFC00_0000;
        prog[18] = enc_r(1, 1, 9, 8'h20);
        prog[19] = enc_i(8'h2B, 0, 8, 28);
        prog[20] = enc_i(8'h2B, 0, 9, 32);
        prog[21] = enc_i(8'h2B, 0, 1, 36);
        prog[22] = enc_i(8'h2B, 0, 1, 40);
        prog[23] = enc_i(8'h2B, 0, 2, 44);
        prog[24] = enc_i(8'h04, 0, 0, 16'hFFFF);

        rst = 1'b1; pre_we = 1'b0; pre_addr = '0; pre_data = '0; dbg_addr = '0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            pre_we = 1'b1; pre_addr = 8'(i); pre_data = prog[i];
        end
        @(negedge clk);
        pre_we = 1'b0;
        repeat (2) @(negedge clk);
        m_pc = 32'd0;
        for (int r = 0; r < 32; r++) m_reg[r] = 32'd0;
        rst = 1'b0;
        #1 chk("R1 pc after reset", pc_o, 32'd0);

        for (int c = 0; c < 40; c++) begin
            @(posedge clk);
            model_step();
            @(negedge clk);
            dbg_addr = 8'(c % 12);
            #1;
            chk("R7 pc per cycle", pc_o, m_pc);
            if (m_mem.exists(c % 12)) chk("R10 debug word per cycle", dbg_data, m_mem[c % 12]);
        end

        dbg_addr = 8'd2;  #1 chk("R2 addu result", dbg_data, 32'h0001_1224);
        dbg_addr = 8'd3;  #1 chk("R3 subu result", dbg_data, 32'hFFFF_1244);
        dbg_addr = 8'd4;  #1 chk("R5 lw negative offset", dbg_data, 32'hFFFF_1244);
        dbg_addr = 8'd5;  #1 chk("R8 r0 stays zero", dbg_data, 32'd0);
        dbg_addr = 8'd6;  #1 chk("R1 register cleared", dbg_data, 32'd0);
        dbg_addr = 8'd7;  #1 chk("R7 skipped instructions", dbg_data, 32'd0);
        dbg_addr = 8'd8;  #1 chk("R9 unknown funct no-op", dbg_data, 32'd0);
        dbg_addr = 8'd9;  #1 chk("R6 store value", dbg_data, 32'h0000_1234);
        dbg_addr = 8'd10; #1 chk("R6 rt unchanged by store", dbg_data, 32'h0000_1234);
        dbg_addr = 8'd11; #1 chk("R4 ori zero extend", dbg_data, 32'h0000_FFF0);
        chk("R7 self branch holds pc", pc_o, 32'd96);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule